// File: doc/BRIEF.md
# Endian-Selectable Duplex Byte FIFO

This block sits between a 16-bit CPU data register and a byte-wide serial engine. It holds two small byte queues: one for transmit and one for receive. On the transmit side the CPU writes two bytes at a time and the engine takes one byte at a time. On the receive side the engine delivers one byte at a time and the CPU reads two bytes at a time. One control input chooses which half of a 16-bit word counts as the earlier byte. This choice applies to both directions.

The block does not keep the status flags itself. Instead it emits one-cycle set and clear pulses for five flags: transmit-ready, receive-ready, transmit-underflow, receive-overrun and single-byte-read. A neighbouring status register applies these pulses. Every strobe is sampled on a rising clock edge, and every result (returned byte, returned word, pulse) appears in the registered outputs one cycle later. When a strobe is absent, the returned byte and the returned word keep their last value.

Top module: `duplex_byte_fifo`

## Requirements
- R1: After synchronous reset both queues are empty, `eng_txbyte` and `cpu_rdata` read zero, and no pulse is active.
- R2: A CPU write is accepted only when at most DEPTH-2 (2 by default) transmit bytes are held, and then it adds two bytes. With 3 or 4 bytes held the write is dropped, and the bytes already queued come out unchanged.
- R3: With `big_end`=1 the byte in `cpu_wdata[15:8]` is queued before `cpu_wdata[7:0]`. With `big_end`=0 the byte in `[7:0]` goes first.
- R4: An accepted write pulses `xudf_clr`. If more than 2 bytes are held once the write is applied, it also pulses `xrdy_clr`. A dropped write pulses neither.
- R5: Each `eng_pop` pulses `xrdy_set` and returns the oldest transmit byte on `eng_txbyte` in the next cycle, removing it from the queue.
- R6: An `eng_pop` with no transmit byte held returns zero and pulses `xudf_set`.
- R7: Each `eng_push` pulses `rrdy_set`. The byte is queued if fewer than DEPTH (4) receive bytes are held. Otherwise it is discarded and `rovr_set` pulses.
- R8: On `cpu_rd`, with b0 the oldest held byte and b1 the next, `cpu_rdata` becomes {b0,b1} when `big_end`=1 and {b1,b0} when `big_end`=0. A position holding no byte reads as zero.
- R9: A read with exactly one byte held empties the receive queue and pulses `sbd_set`. A read with two or more bytes held removes the two oldest bytes and moves the rest forward. A read with nothing held changes nothing.
- R10: Every `cpu_rd` pulses `rovr_clr`.
- R11: Removal happens before addition within one cycle. A pop or read is applied first, and a same-cycle write or push is then judged against the level left behind.
- R12: While `enable` is low both queues are flushed, both returned values are zero, all strobes are ignored and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; low flushes and idles the block |
| big_end | input | 1 | Byte order select for CPU words |
| cpu_wr | input | 1 | CPU data write strobe |
| cpu_wdata | input | 16 | CPU write word |
| cpu_rd | input | 1 | CPU data read strobe |
| cpu_rdata | output | 16 | Word returned by the last read |
| eng_pop | input | 1 | Engine request for a transmit byte |
| eng_txbyte | output | 8 | Byte returned by the last pop |
| eng_push | input | 1 | Engine delivers a received byte |
| eng_rxbyte | input | 8 | Received byte |
| xrdy_set | output | 1 | Transmit-ready set pulse |
| xrdy_clr | output | 1 | Transmit-ready clear pulse |
| xudf_set | output | 1 | Transmit-underflow set pulse |
| xudf_clr | output | 1 | Transmit-underflow clear pulse |
| rrdy_set | output | 1 | Receive-ready set pulse |
| rovr_set | output | 1 | Receive-overrun set pulse |
| rovr_clr | output | 1 | Receive-overrun clear pulse |
| sbd_set | output | 1 | Single-byte-read set pulse |

## Verification
A wrong transmit level or a stale slot becomes visible one cycle after the next pop. That pop either returns the wrong byte or raises `xudf_set` at the wrong time. A later write that is dropped or accepted by mistake changes the byte sequence within at most four pops. A wrong receive level shows on the next read, either as a wrong or unmasked byte in `cpu_rdata` or as a misplaced `sbd_set`. It can also show on the fifth push, as a missing or early `rovr_set`. The bench compares every output after every cycle against an arithmetic queue model, so any such divergence is reported within one to a few operations.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  typedef struct packed {
    logic xrdy_set;
    logic xrdy_clr;
    logic xudf_set;
    logic xudf_clr;
  } tx_pulse_t;

  typedef struct packed {
    logic rrdy_set;
    logic rovr_set;
    logic rovr_clr;
    logic sbd_set;
  } rx_pulse_t;
endpackage

// File: rtl/dbf_tx_lane.sv
module dbf_tx_lane
  import dbf_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                big_end,
  input  logic                wr,
  input  logic [2*BYTE_W-1:0] wdata,
  input  logic                pop,
  output logic [BYTE_W-1:0]   byte_q,
  output tx_pulse_t           pulse_q
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int ROOM = DEPTH - 2;

  logic [BYTE_W-1:0] mem   [DEPTH];
  logic [BYTE_W-1:0] mem_n [DEPTH];
  logic [CW-1:0]     cnt, cnt_n;
  logic [BYTE_W-1:0] first_b, second_b;
  logic              took, empty_pop, accept, crowded;
  int                lvl;

  always_comb begin
    first_b  = big_end ? wdata[2*BYTE_W-1:BYTE_W] : wdata[BYTE_W-1:0];
    second_b = big_end ? wdata[BYTE_W-1:0] : wdata[2*BYTE_W-1:BYTE_W];
    mem_n     = mem;
    lvl       = int'(cnt);
    took      = pop && (cnt != '0);
    empty_pop = pop && (cnt == '0);
    // removal first
    if (took) begin
      for (int i = 0; i < DEPTH - 1; i++) mem_n[i] = mem[i+1];
      mem_n[DEPTH-1] = '0;
      lvl = lvl - 1;
    end
    // then append against the remaining level
    accept = wr && (lvl <= ROOM);
    if (accept) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i == lvl)     mem_n[i] = first_b;
        if (i == lvl + 1) mem_n[i] = second_b;
      end
      lvl = lvl + 2;
    end
    crowded = accept && (lvl > ROOM);
    cnt_n   = CW'(lvl);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt     <= '0;
      byte_q  <= '0;
      pulse_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      cnt <= cnt_n;
      for (int i = 0; i < DEPTH; i++) mem[i] <= mem_n[i];
      if (pop) byte_q <= took ? mem[0] : '0;
      pulse_q.xrdy_set <= pop;
      pulse_q.xudf_set <= empty_pop;
      pulse_q.xudf_clr <= accept;
      pulse_q.xrdy_clr <= crowded;
    end
  end

  assert_tx_level_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  assert_write_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (en && wr && !pop && cnt > CW'(ROOM)) |=> (cnt == $past(cnt) && !pulse_q.xudf_clr));

  assert_underflow_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (en && pop && cnt == '0) |=> (pulse_q.xudf_set && byte_q == '0));
endmodule

// File: rtl/dbf_rx_lane.sv
module dbf_rx_lane
  import dbf_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                big_end,
  input  logic                push,
  input  logic [BYTE_W-1:0]   rx_byte,
  input  logic                rd,
  output logic [2*BYTE_W-1:0] rdata_q,
  output rx_pulse_t           pulse_q
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [BYTE_W-1:0]   mem   [DEPTH];
  logic [BYTE_W-1:0]   mem_n [DEPTH];
  logic [CW-1:0]       cnt, cnt_n;
  logic [BYTE_W-1:0]   b0, b1;
  logic [2*BYTE_W-1:0] word;
  logic                lone, stored, dropped;
  int                  lvl;

  always_comb begin
    b0   = (cnt >= CW'(1)) ? mem[0] : '0;
    b1   = (cnt >= CW'(2)) ? mem[1] : '0;
    word = big_end ? {b0, b1} : {b1, b0};
    mem_n = mem;
    lvl   = int'(cnt);
    lone  = rd && (cnt == CW'(1));
    // read removal first
    if (rd && lvl >= 2) begin
      for (int i = 0; i < DEPTH - 2; i++) mem_n[i] = mem[i+2];
      for (int i = DEPTH - 2; i < DEPTH; i++) mem_n[i] = '0;
      lvl = lvl - 2;
    end else if (lone) begin
      lvl = 0;
    end
    // then arrival against the remaining level
    stored  = push && (lvl < DEPTH);
    dropped = push && (lvl >= DEPTH);
    if (stored) begin
      for (int i = 0; i < DEPTH; i++)
        if (i == lvl) mem_n[i] = rx_byte;
      lvl = lvl + 1;
    end
    cnt_n = CW'(lvl);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt     <= '0;
      rdata_q <= '0;
      pulse_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      cnt <= cnt_n;
      for (int i = 0; i < DEPTH; i++) mem[i] <= mem_n[i];
      if (rd) rdata_q <= word;
      pulse_q.rrdy_set <= push;
      pulse_q.rovr_set <= dropped;
      pulse_q.rovr_clr <= rd;
      pulse_q.sbd_set  <= lone;
    end
  end

  assert_rx_level_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  assert_push_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (en && push && !rd && cnt == CW'(DEPTH)) |=> (pulse_q.rovr_set && cnt == CW'(DEPTH)));

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (en && rd) |=> pulse_q.rovr_clr);

  assert_single_byte_R9: assert property (@(posedge clk) disable iff (rst)
    (en && rd && !push && cnt == CW'(1)) |=> (pulse_q.sbd_set && cnt == '0));
endmodule

// File: rtl/duplex_byte_fifo.sv
module duplex_byte_fifo
  import dbf_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                big_end,
  input  logic                cpu_wr,
  input  logic [2*BYTE_W-1:0] cpu_wdata,
  input  logic                cpu_rd,
  output logic [2*BYTE_W-1:0] cpu_rdata,
  input  logic                eng_pop,
  output logic [BYTE_W-1:0]   eng_txbyte,
  input  logic                eng_push,
  input  logic [BYTE_W-1:0]   eng_rxbyte,
  output logic                xrdy_set,
  output logic                xrdy_clr,
  output logic                xudf_set,
  output logic                xudf_clr,
  output logic                rrdy_set,
  output logic                rovr_set,
  output logic                rovr_clr,
  output logic                sbd_set
);
  tx_pulse_t tx_p;
  rx_pulse_t rx_p;

  dbf_tx_lane #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst(rst), .en(enable), .big_end(big_end),
    .wr(cpu_wr), .wdata(cpu_wdata), .pop(eng_pop),
    .byte_q(eng_txbyte), .pulse_q(tx_p)
  );

  dbf_rx_lane #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst(rst), .en(enable), .big_end(big_end),
    .push(eng_push), .rx_byte(eng_rxbyte), .rd(cpu_rd),
    .rdata_q(cpu_rdata), .pulse_q(rx_p)
  );

  assign xrdy_set = tx_p.xrdy_set;
  assign xrdy_clr = tx_p.xrdy_clr;
  assign xudf_set = tx_p.xudf_set;
  assign xudf_clr = tx_p.xudf_clr;
  assign rrdy_set = rx_p.rrdy_set;
  assign rovr_set = rx_p.rovr_set;
  assign rovr_clr = rx_p.rovr_clr;
  assign sbd_set  = rx_p.sbd_set;

  assert_quiet_disabled_R12: assert property (@(posedge clk) disable iff (rst)
    !enable |=> ({xrdy_set, xrdy_clr, xudf_set, xudf_clr,
                  rrdy_set, rovr_set, rovr_clr, sbd_set} == 8'h00
                 && eng_txbyte == '0 && cpu_rdata == '0));

  assert_pop_ready_R5: assert property (@(posedge clk) disable iff (rst)
    (enable && eng_pop) |=> xrdy_set);
endmodule

// File: tb/duplex_byte_fifo_test.sv
module duplex_byte_fifo_test;
  logic        clk = 0;
  logic        rst = 1, enable = 0, big_end = 0;
  logic        cpu_wr = 0, cpu_rd = 0, eng_pop = 0, eng_push = 0;
  logic [15:0] cpu_wdata = 0;
  logic [7:0]  eng_rxbyte = 0;
  logic [15:0] cpu_rdata;
  logic [7:0]  eng_txbyte;
  logic xrdy_set, xrdy_clr, xudf_set, xudf_clr, rrdy_set, rovr_set, rovr_clr, sbd_set;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [7:0]  txq[$], rxq[$];
  logic [7:0]  exp_tb = 0;
  logic [15:0] exp_rd = 0;

  always #4 clk = ~clk;

  duplex_byte_fifo uut (
    .clk(clk), .rst(rst), .enable(enable), .big_end(big_end),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .eng_pop(eng_pop), .eng_txbyte(eng_txbyte), .eng_push(eng_push), .eng_rxbyte(eng_rxbyte),
    .xrdy_set(xrdy_set), .xrdy_clr(xrdy_clr), .xudf_set(xudf_set), .xudf_clr(xudf_clr),
    .rrdy_set(rrdy_set), .rovr_set(rovr_set), .rovr_clr(rovr_clr), .sbd_set(sbd_set)
  );

  task automatic cmp(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic e, input logic b, input logic w,
                      input logic [15:0] wd, input logic p, input logic pu,
                      input logic [7:0] rb, input logic r);
    logic sx, cx, su, cu, sr, so, cr, sb;
    logic [7:0] b0, b1;
    {sx, cx, su, cu, sr, so, cr, sb} = 8'h00;
    if (!e) begin
      txq.delete(); rxq.delete(); exp_tb = 0; exp_rd = 0;
    end else begin
      if (p) begin
        sx = 1;
        if (txq.size() > 0) exp_tb = txq.pop_front();
        else begin exp_tb = 0; su = 1; end
      end
      if (w && txq.size() <= 2) begin
        txq.push_back(b ? wd[15:8] : wd[7:0]);
        txq.push_back(b ? wd[7:0] : wd[15:8]);
        cu = 1;
        cx = (txq.size() > 2);
      end
      if (r) begin
        cr = 1;
        b0 = (rxq.size() > 0) ? rxq[0] : 8'h00;
        b1 = (rxq.size() > 1) ? rxq[1] : 8'h00;
        exp_rd = b ? {b0, b1} : {b1, b0};
        if (rxq.size() == 1) begin sb = 1; rxq.delete(); end
        else if (rxq.size() > 1) begin rxq.delete(0); rxq.delete(0); end
      end
      if (pu) begin
        sr = 1;
        if (rxq.size() < 4) rxq.push_back(rb); else so = 1;
      end
    end
    enable = e; big_end = b; cpu_wr = w; cpu_wdata = wd; eng_pop = p;
    eng_push = pu; eng_rxbyte = rb; cpu_rd = r;
    @(negedge clk);
    cmp(tag, "eng_txbyte", {8'h00, eng_txbyte}, {8'h00, exp_tb});
    cmp(tag, "cpu_rdata", cpu_rdata, exp_rd);
    cmp(tag, "pulses", {8'h00, xrdy_set, xrdy_clr, xudf_set, xudf_clr, rrdy_set, rovr_set, rovr_clr, sbd_set},
        {8'h00, sx, cx, su, cu, sr, so, cr, sb});
    cpu_wr = 0; cpu_rd = 0; eng_pop = 0; eng_push = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    txq.delete(); rxq.delete(); exp_tb = 0; exp_rd = 0;
    cmp("R1", "eng_txbyte after reset", {8'h00, eng_txbyte}, 16'h0000);
    cmp("R1", "cpu_rdata after reset", cpu_rdata, 16'h0000);
    cmp("R1", "pulses after reset", {8'h00, xrdy_set, xrdy_clr, xudf_set, xudf_clr, rrdy_set, rovr_set, rovr_clr, sbd_set}, 16'h0000);
  endtask

  initial begin
    logic [15:0] lf;
    @(negedge clk);
    do_reset();
    step("R1", 1, 0, 0, 0, 1, 0, 0, 0);
    step("R1", 1, 0, 0, 0, 0, 0, 0, 1);
    for (int b = 0; b < 2; b++) begin
      step("R6", 1, b[0], 0, 0, 1, 0, 0, 0);
      // transmit sweep: every starting level 0..4 then one write and full drain
      for (int lv = 0; lv <= 4; lv++) begin
        for (int k = 0; k < lv; k += 2)
          step("R2", 1, b[0], 1, 16'h1000 + 16'(k * 16'h0101) + 16'(lv), 0, 0, 0, 0);
        if (lv % 2 == 1) step("R2", 1, b[0], 0, 0, 1, 0, 0, 0);
        step("R4", 1, b[0], 1, 16'hA55A ^ 16'(lv * 16'h1111), 0, 0, 0, 0);
        for (int k = 0; k < 6; k++) step("R3", 1, b[0], 0, 0, 1, 0, 0, 0);
      end
      // receive sweep: each level 0..5 pushed, then drained by reads
      for (int lv = 0; lv <= 5; lv++) begin
        for (int k = 0; k < lv; k++) step("R7", 1, b[0], 0, 0, 0, 1, 8'(8'h30 + k + lv * 8), 0);
        for (int k = 0; k < 3; k++) step("R9", 1, b[0], 0, 0, 0, 0, 0, 1);
      end
      // odd count with masking of the absent byte
      step("R8", 1, b[0], 0, 0, 0, 1, 8'hC7, 0);
      step("R8", 1, b[0], 0, 0, 0, 0, 0, 1);
      // same-cycle ordering
      for (int k = 0; k < 4; k++) step("R11", 1, b[0], 0, 0, 0, 1, 8'(8'h50 + k), 0);
      step("R11", 1, b[0], 0, 0, 0, 1, 8'hEE, 1);
      step("R11", 1, b[0], 1, 16'h1234, 0, 0, 0, 0);
      step("R11", 1, b[0], 0, 0, 1, 0, 0, 0);
      step("R11", 1, b[0], 1, 16'h5678, 1, 0, 0, 0);
      step("R11", 1, b[0], 1, 16'h9ABC, 1, 0, 0, 0);
      for (int k = 0; k < 4; k++) step("R10", 1, b[0], 0, 0, 1, 0, 0, 1);
      // disable flushes and ignores strobes
      step("R12", 1, b[0], 1, 16'hBEEF, 0, 1, 8'h77, 0);
      step("R12", 0, b[0], 1, 16'hCAFE, 1, 1, 8'h66, 1);
      step("R12", 0, b[0], 0, 0, 1, 0, 0, 1);
      step("R12", 1, b[0], 0, 0, 1, 0, 0, 1);
    end
    // long mixed sequence
    lf = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("R11", (lf[15:10] != 6'd0), lf[9] & lf[8], lf[0], {lf[7:0], lf[15:8]},
           lf[1], lf[2], lf[11:4], lf[3]);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule